// File: doc/BRIEF.md
# DMA Element Arbiter

This block decides which DMA channels may move data on each clock. It serves six channels and five ports (on-chip memory blocks and peripheral links). Each channel asks for one element at a time. The request names a source port and a destination port, and a priority class (high or low) comes with it. A granted element takes two cycles: a read cycle on the source port, then a write cycle on the destination port. Both ports stay reserved for those two cycles and are released on the cycle after the write. The arbiter decides again after every element, not after every buffer. A high-priority channel that becomes ready during a low-priority buffer therefore waits for at most the element already in flight.

The grant works as a valid/ready handshake. `req` is the valid and the read-grant pulse is the acceptance. A channel holds `req`, its class and its port codes steady until it sees `grant_rd`. If it has no further element, it drops `req` during that read cycle. The arbiter latches the port selection at acceptance, so the fields may change from the read cycle on. Back-pressure comes from three sources: busy ports, ports held by the CPU (`cpu_hold`, one bit per port) and the cap on elements in flight. A channel waits without limit under any of them.

When element transfers use disjoint ports, up to two of them may run at the same time. Within each priority class the choice rotates round-robin, starting after the last channel granted in that class.

Top module: `dma_elem_arbiter`

## Requirements
- R1: While reset is high, and on the first cycle after it, all read and write grants and all port-busy flags are 0. The round-robin start point of both classes returns to channel 0, so among several equal-priority requesters on shared ports channel 0 is granted first.
- R2: If a channel is eligible in cycle k, `grant_rd` for that channel is 1 in cycle k+1 and `grant_wr` is 1 in cycle k+2. Its source and destination bits of `port_busy` are 1 in cycles k+1 and k+2 and return to 0 in cycle k+3, when the channel may be eligible again.
- R3: No port is used by two channels in the same cycle.
- R4: At most two channels hold a read or write grant in any cycle, even when more port-disjoint requests are pending.
- R5: When eligible channels conflict, a high-priority channel (`prio_hi`=1) is always chosen before a low-priority one. A high-priority request that arrives during a low-priority buffer is served as soon as the element in flight releases its ports.
- R6: Among eligible channels of the same class, the search begins at the channel after the last one granted in that class and wraps from the highest index to channel 0.
- R7: Two eligible channels whose ports do not overlap are both granted in the same cycle. The high-priority channels and the earlier channels in round-robin order are picked first.
- R8: While `cpu_hold` bit p is 1, no new element that touches port p is granted. An element already granted completes its write cycle regardless of the hold.
- R9: A channel is eligible only if `req` is 1, it is not already holding a grant, and neither of its ports is busy or held.
- R10: A port code of 5, 6 or 7 is out of range. A channel that selects one is never granted, and other channels are not blocked by it.
- R11: A channel whose source and destination codes are equal occupies a single port. Only that bit of `port_busy` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 6 | Per-channel element request (valid) |
| prio_hi | input | 6 | Per-channel class: 1 = high, 0 = low |
| src_port | input | 18 | Source port code, 3 bits per channel, channel c at bits [3c+2:3c] |
| dst_port | input | 18 | Destination port code, same packing as `src_port` |
| cpu_hold | input | 5 | Per-port CPU hold; bit p blocks new grants on port p |
| grant_rd | output | 6 | Channel is in its read cycle (acceptance of the request) |
| grant_wr | output | 6 | Channel is in its write cycle |
| port_busy | output | 5 | Port is reserved by an element in flight |

## Verification
The bench builds the block at its default parameters: six channels, five ports and a cap of two elements in flight. Five ports are enough room for three single-port self-copies, so the in-flight cap can be reached separately from port exclusion. Six channels in two classes let the round-robin wrap while high-priority channels overtake low-priority ones. Random requests, port codes and CPU holds are compared cycle by cycle against a bench model. Directed cases cover the reset ordering, the preemption bound, the parallel pair, the hold and the out-of-range codes.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2
  } dma_phase_e;

endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int NCH = 6,
  parameter int IW  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] elig,
  input  logic [NCH-1:0] hi,
  input  logic [IW-1:0]  base_hi,
  input  logic [IW-1:0]  base_lo,
  output logic [NCH-1:0] pick,
  output logic           found,
  output logic [IW-1:0]  idx,
  output logic           is_hi
);

  // high class searched completely before the low class, each from its own base
  always_comb begin
    found = 1'b0;
    idx   = '0;
    is_hi = 1'b0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < NCH; k++) begin
        int j;
        j = ((pass == 0) ? int'(base_hi) : int'(base_lo)) + k;
        if (j >= NCH) j = j - NCH;
        if (!found && elig[j] && (hi[j] == (pass == 0))) begin
          found = 1'b1;
          idx   = IW'(j);
          is_hi = (pass == 0);
        end
      end
    end
  end

  assign pick = found ? (NCH'(1) << idx) : '0;

  assert_hi_first_R5: assert property (@(posedge clk) disable iff (rst)
    ((elig & hi) != '0) |-> (is_hi && ((pick & hi) != '0)))
    else $error("high class not chosen first");

  assert_pick_legal_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick) && ((pick & ~elig) == '0) && (found == (elig != '0)))
    else $error("pick not a single eligible channel");

endmodule

// File: rtl/dma_arb_chan.sv
module dma_arb_chan
  import dma_arb_pkg::*;
#(
  parameter int NPORT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NPORT-1:0] use_in,
  output logic             rd,
  output logic             wr,
  output logic [NPORT-1:0] use_q
);

  dma_phase_e       ph;
  logic [NPORT-1:0] ports_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      ports_q <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph      <= PH_RD;
          ports_q <= use_in;
        end
        PH_RD:   ph <= PH_WR;
        PH_WR: begin
          ph      <= PH_IDLE;
          ports_q <= '0;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign rd    = (ph == PH_RD);
  assign wr    = (ph == PH_WR);
  assign use_q = ports_q;

  assert_start_idle_R2: assert property (@(posedge clk) disable iff (rst)
    start |-> (ph == PH_IDLE))
    else $error("start given to a channel already in flight");

  assert_read_has_port_R3: assert property (@(posedge clk) disable iff (rst)
    rd |-> (use_q != '0))
    else $error("read cycle without reserved port");

endmodule

// File: rtl/dma_elem_arbiter.sv
module dma_elem_arbiter #(
  parameter int NCH        = 6,
  parameter int NPORT      = 5,
  parameter int MAX_FLIGHT = 2,
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    req,
  input  logic [NCH-1:0]    prio_hi,
  input  logic [NCH*PW-1:0] src_port,
  input  logic [NCH*PW-1:0] dst_port,
  input  logic [NPORT-1:0]  cpu_hold,
  output logic [NCH-1:0]    grant_rd,
  output logic [NCH-1:0]    grant_wr,
  output logic [NPORT-1:0]  port_busy
);

  logic [NPORT-1:0] use_oh [NCH];
  logic [NPORT-1:0] ch_use [NCH];
  logic [NCH-1:0]   range_ok;
  logic [NCH-1:0]   active;
  logic [NCH-1:0]   elig0;
  logic [NCH-1:0]   start;
  logic [IW-1:0]    base_hi, base_lo;
  int               n_active;

  // port decode of each channel's request
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      range_ok[c] = (int'(src_port[c*PW +: PW]) < NPORT) &&
                    (int'(dst_port[c*PW +: PW]) < NPORT);
      for (int p = 0; p < NPORT; p++) begin
        use_oh[c][p] = (src_port[c*PW +: PW] == PW'(p)) ||
                       (dst_port[c*PW +: PW] == PW'(p));
      end
    end
  end

  assign active = grant_rd | grant_wr;

  always_comb begin
    port_busy = '0;
    for (int c = 0; c < NCH; c++) port_busy = port_busy | ch_use[c];
  end

  always_comb n_active = $countones(active);

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      elig0[c] = req[c] && !active[c] && range_ok[c] &&
                 ((use_oh[c] & (port_busy | cpu_hold)) == '0);
    end
  end

  // selection stages, one per transfer that may start in a cycle
  wire [NCH-1:0]   picked_acc [MAX_FLIGHT+1];
  wire [NPORT-1:0] taken_acc  [MAX_FLIGHT+1];
  wire             st_fnd     [MAX_FLIGHT];
  wire             st_hi      [MAX_FLIGHT];
  wire [IW-1:0]    st_idx     [MAX_FLIGHT];

  assign picked_acc[0] = '0;
  assign taken_acc[0]  = '0;

  for (genvar s = 0; s < MAX_FLIGHT; s++) begin : g_stage
    logic [NCH-1:0]   el;
    logic [NCH-1:0]   pk;
    logic [NPORT-1:0] pk_ports;
    logic             room;

    always_comb begin
      room = (n_active + s) < MAX_FLIGHT;
      for (int c = 0; c < NCH; c++) begin
        el[c] = elig0[c] && !picked_acc[s][c] &&
                ((use_oh[c] & taken_acc[s]) == '0) && room;
      end
    end

    dma_arb_pick #(.NCH(NCH), .IW(IW)) u_pick (
      .clk     (clk),
      .rst     (rst),
      .elig    (el),
      .hi      (prio_hi),
      .base_hi (base_hi),
      .base_lo (base_lo),
      .pick    (pk),
      .found   (st_fnd[s]),
      .idx     (st_idx[s]),
      .is_hi   (st_hi[s])
    );

    always_comb begin
      pk_ports = '0;
      for (int c = 0; c < NCH; c++) if (pk[c]) pk_ports = pk_ports | use_oh[c];
    end

    assign picked_acc[s+1] = picked_acc[s] | pk;
    assign taken_acc[s+1]  = taken_acc[s] | pk_ports;
  end

  assign start = picked_acc[MAX_FLIGHT];

  function automatic logic [IW-1:0] after_ch(input logic [IW-1:0] i);
    return (int'(i) == NCH - 1) ? '0 : i + 1'b1;
  endfunction

  // round-robin bases: the later stage of a class wins
  always_ff @(posedge clk) begin
    if (rst) begin
      base_hi <= '0;
      base_lo <= '0;
    end else begin
      for (int s = 0; s < MAX_FLIGHT; s++) begin
        if (st_fnd[s]) begin
          if (st_hi[s]) base_hi <= after_ch(st_idx[s]);
          else          base_lo <= after_ch(st_idx[s]);
        end
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dma_arb_chan #(.NPORT(NPORT)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .start  (start[c]),
      .use_in (use_oh[c]),
      .rd     (grant_rd[c]),
      .wr     (grant_wr[c]),
      .use_q  (ch_use[c])
    );

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      grant_rd[c] |-> (($past(cpu_hold) & ch_use[c]) == '0))
      else $error("grant on a held port");

    assert_range_R10: assert property (@(posedge clk) disable iff (rst)
      grant_rd[c] |-> $past(range_ok[c]))
      else $error("grant with out-of-range port code");
  end

  logic [NCH-1:0] port_users [NPORT];
  always_comb begin
    for (int p = 0; p < NPORT; p++)
      for (int c = 0; c < NCH; c++) port_users[p][c] = ch_use[c][p];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port_chk
    assert_port_excl_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(port_users[p]))
      else $error("port shared by two channels");
  end

  assert_inflight_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(active) <= MAX_FLIGHT)
    else $error("too many elements in flight");

endmodule

// File: tb/test_dma_elem_arbiter.sv
`timescale 1ns/1ps
module test_dma_elem_arbiter;
  localparam int NCH = 6, NPORT = 5, MAXF = 2, PW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst = 1'b1;
  logic [NCH-1:0]    req = '0, prio = '0;
  logic [PW-1:0]     src_v [NCH], dst_v [NCH];
  logic [NCH*PW-1:0] src_flat, dst_flat;
  logic [NPORT-1:0]  hold = '0;
  logic [NCH-1:0]    grant_rd, grant_wr;
  logic [NPORT-1:0]  port_busy;

  always_comb
    for (int c = 0; c < NCH; c++) begin
      src_flat[c*PW +: PW] = src_v[c];
      dst_flat[c*PW +: PW] = dst_v[c];
    end

  dma_elem_arbiter i_dma_elem_arbiter (
    .clk(clk), .rst(rst), .req(req), .prio_hi(prio), .src_port(src_flat),
    .dst_port(dst_flat), .cpu_hold(hold), .grant_rd(grant_rd),
    .grant_wr(grant_wr), .port_busy(port_busy));

  int checks = 0, failures = 0;
  bit finished = 0;
  int pend [NCH];
  int glog [$];
  int m_ph [NCH];
  logic [NPORT-1:0] m_use [NCH];
  int m_bhi = 0, m_blo = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NPORT-1:0] pmask(input int c);
    logic [NPORT-1:0] m = '0;
    m[src_v[c]] = 1'b1;
    m[dst_v[c]] = 1'b1;
    return m;
  endfunction

  // bench model of the requirements, advanced once per clock
  task automatic model_next();
    logic [NPORT-1:0] busy, taken;
    logic [NCH-1:0] got;
    int nact, best, base, j;
    int nph [NCH];
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin m_ph[c] = 0; m_use[c] = '0; end
      m_bhi = 0; m_blo = 0;
      return;
    end
    busy = '0; taken = '0; got = '0; nact = 0;
    for (int c = 0; c < NCH; c++) begin
      if (m_ph[c] != 0) begin busy |= m_use[c]; nact++; end
      nph[c] = (m_ph[c] == 1) ? 2 : 0;
    end
    for (int s = 0; s < MAXF; s++) begin
      best = -1;
      if (nact + s < MAXF) begin
        for (int pass = 0; pass < 2; pass++) begin
          base = (pass == 0) ? m_bhi : m_blo;
          for (int k = 0; k < NCH; k++) begin
            j = (base + k) % NCH;
            if (best < 0 && req[j] && m_ph[j] == 0 && !got[j] &&
                prio[j] == (pass == 0) && src_v[j] < NPORT && dst_v[j] < NPORT &&
                (pmask(j) & (busy | hold | taken)) == '0)
              best = j;
          end
        end
      end
      if (best >= 0) begin
        got[best] = 1'b1;
        taken |= pmask(best);
        nph[best] = 1;
        if (prio[best]) m_bhi = (best + 1) % NCH; else m_blo = (best + 1) % NCH;
      end
    end
    for (int c = 0; c < NCH; c++) begin
      if (nph[c] == 0) m_use[c] = '0;
      else if (got[c]) m_use[c] = pmask(c);
      m_ph[c] = nph[c];
    end
  endtask

  task automatic cycle();
    logic [NCH-1:0] er, ew;
    logic [NPORT-1:0] eb;
    model_next();
    @(negedge clk);
    er = '0; ew = '0; eb = '0;
    for (int c = 0; c < NCH; c++) begin
      er[c] = (m_ph[c] == 1);
      ew[c] = (m_ph[c] == 2);
      eb |= m_use[c];
    end
    chk(grant_rd == er, "R2 read grant vs model (R5 R6 R7 R9 order)", 32'(grant_rd), 32'(er));
    chk(grant_wr == ew, "R2 write grant vs model", 32'(grant_wr), 32'(ew));
    chk(port_busy == eb, "R3 port busy vs model", 32'(port_busy), 32'(eb));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      for (int c = 0; c < NCH; c++) req[c] = pend[c] > 0;
      cycle();
      for (int c = 0; c < NCH; c++)
        if (m_ph[c] == 1) begin pend[c]--; glog.push_back(c); end
    end
  endtask

  task automatic set_ch(input int c, input bit h, input int s, input int d, input int n);
    prio[c] = h; src_v[c] = PW'(s); dst_v[c] = PW'(d); pend[c] = n;
  endtask

  task automatic do_reset();
    rst = 1'b1; hold = '0;
    for (int c = 0; c < NCH; c++) set_ch(c, 0, 0, 0, 0);
    run(2);
    rst = 1'b0;
    glog.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < NCH; c++) begin src_v[c] = '0; dst_v[c] = '0; pend[c] = 0; end

    // R1: requests present during reset give nothing
    rst = 1'b1;
    for (int c = 0; c < NCH; c++) set_ch(c, 0, 2, 3, 1);
    run(3);
    chk(grant_rd == '0 && grant_wr == '0, "R1 grants in reset", 32'(grant_rd | grant_wr), 0);
    chk(port_busy == '0, "R1 busy in reset", 32'(port_busy), 0);
    do_reset();
    chk(grant_rd == '0 && port_busy == '0, "R1 first cycle after reset", 32'(port_busy), 0);

    // R2: timing of one element
    set_ch(1, 0, 0, 1, 1);
    run(1);
    chk(grant_rd == 6'b000010, "R2 read cycle", 32'(grant_rd), 32'h2);
    chk(port_busy == 5'b00011, "R2 busy in read", 32'(port_busy), 32'h3);
    run(1);
    chk(grant_wr == 6'b000010 && grant_rd == '0, "R2 write cycle", 32'(grant_wr), 32'h2);
    run(1);
    chk(port_busy == '0 && grant_wr == '0, "R2 release", 32'(port_busy), 0);

    // R6 + R1: rotation from channel 0 after reset
    do_reset();
    set_ch(0, 0, 2, 3, 2); set_ch(2, 0, 3, 2, 2); set_ch(4, 0, 2, 3, 2);
    run(20);
    chk(glog.size() == 6, "R6 grant count", 32'(glog.size()), 6);
    if (glog.size() == 6) begin
      chk(glog[0] == 0, "R1 channel 0 first after reset", 32'(glog[0]), 0);
      chk(glog[1] == 2 && glog[2] == 4 && glog[3] == 0 && glog[4] == 2 && glog[5] == 4,
          "R6 round-robin order", 32'(glog[1] * 1000 + glog[2] * 100 + glog[3] * 10 + glog[5]), 32'd2404);
    end

    // R5: high before low on a tie, and preemption after one element
    do_reset();
    set_ch(1, 0, 0, 1, 2); set_ch(3, 1, 1, 2, 2);
    run(20);
    chk(glog.size() == 4 && glog[0] == 3 && glog[1] == 3 && glog[2] == 1,
        "R5 high class first", 32'(glog.size() > 0 ? glog[0] : 99), 3);
    do_reset();
    set_ch(1, 0, 0, 1, 4);
    run(2);
    set_ch(3, 1, 1, 2, 1);
    run(20);
    chk(glog.size() == 5 && glog[1] == 3, "R5 high waits one element only",
        32'(glog.size() > 1 ? glog[1] : 99), 3);

    // R7: disjoint pair granted together
    do_reset();
    set_ch(0, 0, 0, 1, 1); set_ch(1, 0, 2, 3, 1);
    run(1);
    chk(grant_rd == 6'b000011, "R7 parallel grant", 32'(grant_rd), 32'h3);

    // R4 + R11: three single-port copies, cap of two
    do_reset();
    set_ch(0, 0, 0, 0, 1); set_ch(1, 0, 1, 1, 1); set_ch(2, 0, 2, 2, 1);
    run(1);
    chk(grant_rd == 6'b000011, "R4 only two in flight", 32'(grant_rd), 32'h3);
    chk(port_busy == 5'b00011, "R11 single port per self-copy", 32'(port_busy), 32'h3);
    run(2);
    chk(grant_rd == '0, "R4 third still waiting", 32'(grant_rd), 0);
    run(1);
    chk(grant_rd == 6'b000100, "R4 third granted after release", 32'(grant_rd), 32'h4);
    run(3);

    // R8: CPU hold
    do_reset();
    hold = 5'b10000;
    set_ch(5, 0, 4, 0, 1);
    run(4);
    chk(grant_rd == '0 && port_busy == '0, "R8 held port blocks grant", 32'(grant_rd), 0);
    hold = '0;
    run(1);
    chk(grant_rd == 6'b100000, "R8 grant after hold release", 32'(grant_rd), 32'h20);
    hold = 5'b00001;
    run(1);
    chk(grant_wr == 6'b100000 && port_busy == 5'b10001, "R8 in-flight element completes",
        32'(grant_wr), 32'h20);
    hold = '0;
    run(2);

    // R10 + R9: out-of-range code never granted, does not block others
    do_reset();
    set_ch(2, 0, 6, 1, 1); set_ch(4, 0, 1, 2, 1);
    run(1);
    chk(grant_rd == 6'b010000, "R10 valid channel proceeds", 32'(grant_rd), 32'h10);
    run(6);
    chk(pend[2] == 1, "R10 out-of-range never granted", 32'(pend[2]), 1);
    chk(port_busy == '0, "R9 idle with nothing eligible", 32'(port_busy), 0);
    pend[2] = 0;

    // random traffic against the model
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      for (int c = 0; c < NCH; c++)
        if (pend[c] == 0 && m_ph[c] == 0 && ($urandom % 4) == 0)
          set_ch(c, ($urandom % 3) == 0, $urandom % NPORT, $urandom % NPORT, 1 + $urandom % 4);
      hold = (($urandom % 4) == 0) ? NPORT'($urandom) & NPORT'($urandom) : '0;
      run(1);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule